// File: doc/BRIEF.md
# Key Pad Select-and-Read Register

This block is a single byte-wide register through which a processor reads an eight-key pad. The eight keys come in as an active-high vector and are treated as two groups of four. The processor writes two active-low group-select bits into the register. A read of the same address returns the chosen group in the low nibble, inverted so that a pressed key reads as 0. The upper nibble returns whatever was last written there.

Key inputs are asynchronous to the bus clock. They pass through a synchroniser before they are used. The block also raises a one-cycle interrupt request whenever a line that is currently presented in the low nibble falls from 1 to 0. That happens when a key in the selected group is pressed, or when a select change brings a pressed key into view.

The bus port has no handshake. Every access completes in the cycle it is presented, and the block never applies back-pressure. Read data is combinational during a read cycle, and a write takes effect at the clock edge that ends the cycle.

Top module: `keypad_port`

## Requirements
- R1: A write to address 0xFF00 stores data bits 7:4, and a read of 0xFF00 returns those four bits unchanged in bits 7:4.
- R2: When stored bit 5 is 0 and stored bit 6 is 1, read bits 3:0 equal the inverse of keys 7:4.
- R3: When stored bit 5 is 1 and stored bit 6 is 0, read bits 3:0 equal the inverse of keys 3:0.
- R4: When stored bits 5 and 6 are both 0, bit 5 wins and read bits 3:0 equal the inverse of keys 7:4.
- R5: When stored bits 5 and 6 are both 1, read bits 3:0 are 0xF whatever the keys.
- R6: A key change at the input first appears in read data after two rising clock edges, and not after one.
- R7: `irq_o` is high for exactly the cycle in which some presented low-nibble line is 0 where it was 1 in the previous cycle. A line rising from 0 to 1 raises no request.
- R8: A read or write at any other address leaves the stored bits unchanged. During such a read, `bus_rvalid` is 0 and `bus_rdata` is 0x00.
- R9: After reset, a read of 0xFF00 returns 0xFF and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Access address |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_rdata | output | 8 | Read data, 0x00 unless this register is read |
| bus_rvalid | output | 1 | High while a read of this register is presented |
| keys_i | input | 8 | Key states, 1 = pressed; bits 7:4 and 3:0 form the groups |
| irq_o | output | 1 | One-cycle request on a falling presented line |

## Verification
The state that matters is the stored select nibble, the two synchroniser stages and the remembered copy of the presented nibble. A wrong select bit shows up at the very next read of 0xFF00, either in the echoed upper nibble or as the wrong group in the lower one. A fault in a synchroniser stage shifts the cycle in which a key change becomes visible, so it is caught by reads in the cycles right after a key change. A fault in the remembered nibble shows as a missing, extra or stretched interrupt pulse in the cycle after the fault. The reference model is compared against the ports on every clock, so any of these faults is reported within one or two cycles.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int unsigned GROUP_W = 4;
  typedef logic [GROUP_W-1:0] group_t;

  // inverted view of one group: pressed (1) becomes 0
  function automatic group_t present(input group_t pressed);
    return ~pressed;
  endfunction
endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '0;
        else if (g == 0) chain[g] <= d_i;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      logic [1:0] since_rst;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
      end
      p_two_edge_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (q_o == $past(d_i, 2)));
    end
  endgenerate
endmodule

// File: rtl/kp_select.sv
module kp_select
  import kp_pkg::*;
(
  input  logic       hi_sel_n,
  input  logic       lo_sel_n,
  input  logic [7:0] keys,
  output group_t     lines_o
);
  always_comb begin
    if (!hi_sel_n)      lines_o = present(keys[7:4]);
    else if (!lo_sel_n) lines_o = present(keys[3:0]);
    else                lines_o = '1;
  end
endmodule

// File: rtl/kp_fall_detect.sv
module kp_fall_detect
  import kp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  group_t lines_i,
  output logic   fall_o
);
  group_t prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= lines_i;
  end

  assign fall_o = |(prev_q & ~lines_i);
endmodule

// File: rtl/keypad_port.sv
module keypad_port
  import kp_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 16,
  parameter logic [ADDR_W-1:0]    REG_ADDR = 16'hFF00,
  parameter int unsigned          SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  output logic              bus_rvalid,
  input  logic [7:0]        keys_i,
  output logic              irq_o
);
  localparam int unsigned HI_SEL = 1; // data bit 5 within the upper nibble
  localparam int unsigned LO_SEL = 2; // data bit 6 within the upper nibble

  logic       hit;
  logic [3:0] upper_q;
  logic [7:0] keys_s;
  group_t     lines;

  assign hit = (bus_addr == REG_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            upper_q <= 4'hF;
    else if (bus_wr && hit) upper_q <= bus_wdata[7:4];
  end

  kp_sync #(.WIDTH(8), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(keys_i), .q_o(keys_s)
  );

  kp_select u_sel (
    .hi_sel_n(upper_q[HI_SEL]),
    .lo_sel_n(upper_q[LO_SEL]),
    .keys(keys_s),
    .lines_o(lines)
  );

  kp_fall_detect u_fall (
    .clk(clk), .rst_n(rst_n), .lines_i(lines), .fall_o(irq_o)
  );

  assign bus_rvalid = bus_rd && hit;
  assign bus_rdata  = bus_rvalid ? {upper_q, lines} : 8'h00;

  p_irq_sees_low_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (lines != 4'hF));

  p_idle_no_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upper_q[HI_SEL] && upper_q[LO_SEL] && $past(upper_q[HI_SEL] && upper_q[LO_SEL]))
      |-> !irq_o);

  p_hold_without_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr && hit) |-> $stable(upper_q));

  p_capture_on_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit) |=> (upper_q == $past(bus_wdata[7:4])));
endmodule

// File: tb/tb_keypad_port.sv
module tb_keypad_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  keys_i = 8'h00;
  logic        irq_o;

  always #10 clk = ~clk;

  keypad_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .keys_i(keys_i), .irq_o(irq_o)
  );

  int    n_checks = 0;
  int    n_errs   = 0;
  string tag      = "R9";
  bit    finished = 0;

  // behavioural reference state
  int m_upper;
  int m_k1, m_k2;
  int m_prev;

  function automatic int shown(input int up, input int k);
    if (((up >> 1) & 1) == 0) return (~(k >> 4)) & 15;
    if (((up >> 2) & 1) == 0) return (~k) & 15;
    return 15;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_upper = 15; m_k1 = 0; m_k2 = 0; m_prev = 15;
    end else begin
      m_prev = shown(m_upper, m_k2);
      if (bus_wr && bus_addr == 16'hFF00) m_upper = bus_wdata >> 4;
      m_k2 = m_k1;
      m_k1 = keys_i;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int cur, e_irq;
      cur   = shown(m_upper, m_k2);
      e_irq = ((m_prev & ~cur) != 0) ? 1 : 0;
      check("R7", irq_o, e_irq);
      if (bus_rd && bus_addr == 16'hFF00) begin
        check(tag, bus_rvalid, 1);
        check(tag, bus_rdata, (m_upper << 4) | cur);
      end else begin
        check("R8", bus_rvalid, 0);
        check("R8", bus_rdata, 0);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
    tick();
    bus_rd = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_errs++;
    n_checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tag = "R9"; rd(16'hFF00); rd(16'hFF00);
    // R9 directed: reset value
    bus_addr = 16'hFF00; bus_rd = 1'b1; #8;
    check("R9", bus_rdata, 8'hFF);
    check("R9", irq_o, 0);
    tick(); bus_rd = 1'b0;

    keys_i = 8'h5A; repeat (3) tick();
    tag = "R1"; wr(16'hFF00, 8'h3C); rd(16'hFF00);
    tag = "R2"; wr(16'hFF00, 8'hD0); rd(16'hFF00);
    bus_addr = 16'hFF00; bus_rd = 1'b1; #8;
    check("R2", bus_rdata, 8'hDA); // ~5 = A
    tick(); bus_rd = 1'b0;
    tag = "R3"; wr(16'hFF00, 8'hB0); rd(16'hFF00);
    bus_addr = 16'hFF00; bus_rd = 1'b1; #8;
    check("R3", bus_rdata, 8'hB5); // ~A = 5
    tick(); bus_rd = 1'b0;
    tag = "R4"; wr(16'hFF00, 8'h90); rd(16'hFF00);
    bus_addr = 16'hFF00; bus_rd = 1'b1; #8;
    check("R4", bus_rdata, 8'h9A);
    tick(); bus_rd = 1'b0;
    tag = "R5"; wr(16'hFF00, 8'hF0);
    keys_i = 8'hFF; repeat (3) rd(16'hFF00);
    bus_addr = 16'hFF00; bus_rd = 1'b1; #8;
    check("R5", bus_rdata, 8'hFF);
    tick(); bus_rd = 1'b0;

    // R6: key visible after two edges, not one
    tag = "R6"; wr(16'hFF00, 8'hB0); keys_i = 8'h00; repeat (3) rd(16'hFF00);
    keys_i = 8'h03; bus_addr = 16'hFF00; bus_rd = 1'b1;
    tick(); #8; check("R6", bus_rdata, 8'hBF);
    #10; #2; #8; check("R6", bus_rdata, 8'hBC);
    #12; bus_rd = 1'b0;
    for (int i = 0; i < 24; i++) begin
      keys_i = 8'(i * 37 + 11);
      rd(16'hFF00);
    end

    // R7: press then release in selected group
    tag = "R7"; keys_i = 8'h00; repeat (4) tick();
    keys_i = 8'h04; repeat (4) tick();
    keys_i = 8'h00; repeat (4) tick();
    wr(16'hFF00, 8'hF0); keys_i = 8'h10; repeat (3) tick();
    wr(16'hFF00, 8'hD0); repeat (3) tick();   // select change exposes pressed key
    for (int i = 0; i < 30; i++) begin
      keys_i = 8'(i * 91 + 5);
      if (i % 7 == 0) wr(16'hFF00, 8'(i * 16 + 64)); else tick();
    end

    // R8: other addresses
    tag = "R8"; wr(16'hFF00, 8'hB0); keys_i = 8'h00; repeat (3) tick();
    wr(16'hFF01, 8'h00); wr(16'h7F00, 8'h10); rd(16'hFF01); rd(16'h0000);
    bus_addr = 16'hFF00; bus_rd = 1'b1; #8;
    check("R8", bus_rdata, 8'hBF);
    tick(); bus_rd = 1'b0;

    repeat (3) tick();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule